// File: doc/BRIEF.md
# Prioritised Exception Entry Controller

This block decides which exception a processor core enters when several are pending at once. It watches seven kinds of request: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction and software trap. At each instruction boundary it picks one of them by a fixed priority. It then issues a single-cycle entry strobe. The strobe carries the vector address, the new 5-bit mode code, the interrupt-mask bits to set, the return address the core must save, and a pulse that copies the current status word into the saved-status register of the target mode.

The two interrupt pins are active-low, asynchronous and level-sensitive. Each passes through a register chain inside the block before the arbiter sees it. The core supplies its current I and F mask bits, so a masked interrupt is passed over and the next request in priority order is taken. The core also supplies the address of the next instruction and the address of the faulting instruction. The block derives the return address from whichever of the two applies. Undefined instruction and software trap are never raised together.

While the block reset is high, no entry is issued. On the first clock edge after the reset is released, a reset entry is issued whether or not a boundary is present.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high, `entry_valid` is 0. In the cycle after the first rising clock edge with `rst` low, the block issues a reset entry, with or without `boundary`. That entry has vector 0x00, mode 5'b10011, `set_i_mask`=1, `set_f_mask`=1, `save_status`=0 and `ret_addr`=0.
- R2: When several requests are pending at one boundary, the one entered is chosen by this priority, highest first: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction or software trap.
- R3: The vector for each exception is: undefined instruction 0x04, software trap 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R4: The mode code for each exception is: fast interrupt 5'b10001, normal interrupt 5'b10010, software trap 5'b10011, both aborts 5'b10111, undefined instruction 5'b11011.
- R5: Every entry sets `set_i_mask`. `set_f_mask` is set only for a fast interrupt entry and for a reset entry.
- R6: The return address, taken modulo 2^AW, depends on the exception. Interrupts give `next_pc`+4. A prefetch abort gives `fault_pc`+4. A data abort gives `fault_pc`+8. An undefined instruction or software trap gives `next_pc`.
- R7: Each interrupt pin goes through SYNC_STAGES register stages before the arbiter sees it. With one stage, a low level that first appears at the boundary's own clock edge is not taken. The pin must already have been low at the previous edge.
- R8: A fast interrupt is not taken while `f_masked` is 1, and a normal interrupt is not taken while `i_masked` is 1. In either case the next pending request in priority order is entered instead, or no entry is issued if none is pending.
- R9: Outside the reset entry, no entry is issued in a cycle that follows an edge where `boundary` was low, even if requests are pending.
- R10: An entry is a one-cycle strobe in the cycle after the boundary edge. For all entries except reset, `save_status` is high together with `entry_valid`. When `entry_valid` is low, `set_i_mask`, `set_f_mask` and `save_status` are all low.
- R11: A data abort and a fast interrupt at the same boundary produce a data abort entry. If the fast interrupt pin is still low and `f_masked` is still clear, the fast interrupt is entered at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset; its release triggers the reset entry |
| boundary | input | 1 | High for one cycle at an instruction boundary |
| dabt_req | input | 1 | Data abort pending |
| pabt_req | input | 1 | Prefetch abort pending on the instruction about to execute |
| undef_req | input | 1 | Undefined instruction pending |
| swi_req | input | 1 | Software trap pending |
| fiq_n | input | 1 | Fast interrupt, active-low, asynchronous level |
| irq_n | input | 1 | Normal interrupt, active-low, asynchronous level |
| i_masked | input | 1 | Current I mask bit of the status word |
| f_masked | input | 1 | Current F mask bit of the status word |
| next_pc | input | AW | Address of the next instruction to execute |
| fault_pc | input | AW | Address of the aborting instruction |
| entry_valid | output | 1 | Entry strobe |
| entry_vec | output | AW | Vector address of the entry |
| entry_mode | output | 5 | New mode code |
| set_i_mask | output | 1 | Set the I mask bit |
| set_f_mask | output | 1 | Set the F mask bit |
| ret_addr | output | AW | Return address to save in the target mode's link register |
| save_status | output | 1 | Copy the status word into the saved-status register of the target mode |

## Verification
The bench builds the block with AW=16 and SYNC_STAGES=1. The narrow address width lets a data abort at 0xFFFC wrap its return address to 0x0004, which tests the modulo rule with few bits. A single synchroniser stage makes the one-edge delay of the interrupt pins directly observable. A pin that drops at the boundary edge itself must be missed, and the same pin must be taken at the next boundary.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        EX_NONE, EX_RESET, EX_DABT, EX_FIQ, EX_IRQ, EX_PABT, EX_UNDEF, EX_SWI
    } exc_kind_e;

    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_UND = 5'b11011;

    // Per-entry control fields carried from the arbiter to the output register
    typedef struct packed {
        logic       valid;
        logic [4:0] vec;
        logic [4:0] mode;
        logic       set_i;
        logic       set_f;
        logic       save;
        logic [3:0] ret_off;
        logic       from_fault;
    } entry_t;

    function automatic entry_t decode_entry(exc_kind_e k);
        entry_t e;
        e = '0;
        e.valid = (k != EX_NONE);
        e.set_i = (k != EX_NONE);
        e.save  = (k != EX_NONE) && (k != EX_RESET);
        unique case (k)
            EX_RESET: begin e.vec = 5'h00; e.mode = MODE_SVC; e.set_f = 1'b1; end
            EX_DABT:  begin e.vec = 5'h10; e.mode = MODE_ABT; e.ret_off = 4'd8; e.from_fault = 1'b1; end
            EX_FIQ:   begin e.vec = 5'h1C; e.mode = MODE_FIQ; e.set_f = 1'b1; e.ret_off = 4'd4; end
            EX_IRQ:   begin e.vec = 5'h18; e.mode = MODE_IRQ; e.ret_off = 4'd4; end
            EX_PABT:  begin e.vec = 5'h0C; e.mode = MODE_ABT; e.ret_off = 4'd4; e.from_fault = 1'b1; end
            EX_UNDEF: begin e.vec = 5'h04; e.mode = MODE_UND; end
            EX_SWI:   begin e.vec = 5'h08; e.mode = MODE_SVC; end
            default:  ;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/exc_level_sync.sv
module exc_level_sync #(
    parameter int   STAGES = 1,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= IDLE;
                else     chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{IDLE}};
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic      reset_pend,
    input  logic      boundary,
    input  logic      dabt_req,
    input  logic      fiq_low,
    input  logic      irq_low,
    input  logic      i_masked,
    input  logic      f_masked,
    input  logic      pabt_req,
    input  logic      undef_req,
    input  logic      swi_req,
    output exc_kind_e pick
);
    logic fiq_take, irq_take;

    assign fiq_take = fiq_low && !f_masked;
    assign irq_take = irq_low && !i_masked;

    always_comb begin
        pick = EX_NONE;
        if (reset_pend)         pick = EX_RESET;
        else if (boundary) begin
            if (dabt_req)       pick = EX_DABT;
            else if (fiq_take)  pick = EX_FIQ;
            else if (irq_take)  pick = EX_IRQ;
            else if (pabt_req)  pick = EX_PABT;
            else if (undef_req) pick = EX_UNDEF;
            else if (swi_req)   pick = EX_SWI;
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int AW          = 32,
    parameter int SYNC_STAGES = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          boundary,
    input  logic          dabt_req,
    input  logic          pabt_req,
    input  logic          undef_req,
    input  logic          swi_req,
    input  logic          fiq_n,
    input  logic          irq_n,
    input  logic          i_masked,
    input  logic          f_masked,
    input  logic [AW-1:0] next_pc,
    input  logic [AW-1:0] fault_pc,
    output logic          entry_valid,
    output logic [AW-1:0] entry_vec,
    output logic [4:0]    entry_mode,
    output logic          set_i_mask,
    output logic          set_f_mask,
    output logic [AW-1:0] ret_addr,
    output logic          save_status
);
    localparam int VEC_PAD = AW - 5;

    logic [1:0]    pin_n, pin_s;
    logic          reset_pend;
    exc_kind_e     pick;
    entry_t        nxt, cur;
    logic [AW-1:0] base, ret_q;

    assign pin_n = {fiq_n, irq_n};

    // One synchroniser per interrupt pin: [1] fast, [0] normal
    generate
        for (genvar g = 0; g < 2; g++) begin : g_sync
            exc_level_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
                .clk (clk),
                .rst (rst),
                .din (pin_n[g]),
                .dout(pin_s[g])
            );
        end
    endgenerate

    exc_arbiter u_arb (
        .reset_pend(reset_pend),
        .boundary  (boundary),
        .dabt_req  (dabt_req),
        .fiq_low   (!pin_s[1]),
        .irq_low   (!pin_s[0]),
        .i_masked  (i_masked),
        .f_masked  (f_masked),
        .pabt_req  (pabt_req),
        .undef_req (undef_req),
        .swi_req   (swi_req),
        .pick      (pick)
    );

    assign nxt  = decode_entry(pick);
    assign base = nxt.from_fault ? fault_pc : next_pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            reset_pend <= 1'b1;
            cur        <= '0;
            ret_q      <= '0;
        end else begin
            if (pick == EX_RESET) reset_pend <= 1'b0;
            cur   <= nxt;
            ret_q <= (pick == EX_RESET || pick == EX_NONE) ? '0
                                                            : base + AW'(nxt.ret_off);
        end
    end

    assign entry_valid = cur.valid;
    assign entry_vec   = {{VEC_PAD{1'b0}}, cur.vec};
    assign entry_mode  = cur.mode;
    assign set_i_mask  = cur.set_i;
    assign set_f_mask  = cur.set_f;
    assign save_status = cur.save;
    assign ret_addr    = ret_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          boundary,
    input logic          f_masked,
    input logic [AW-1:0] fault_pc,
    input logic          entry_valid,
    input logic [AW-1:0] entry_vec,
    input logic [4:0]    entry_mode,
    input logic          set_i_mask,
    input logic          set_f_mask,
    input logic [AW-1:0] ret_addr,
    input logic          save_status
);
    // R1
    reset_entry_chk: assert property (@(posedge clk) disable iff (rst)
        entry_valid && !$past(boundary) |-> entry_mode == 5'b10011 && entry_vec == '0 && set_f_mask);

    // R5
    i_always_set_chk: assert property (@(posedge clk) disable iff (rst)
        entry_valid |-> set_i_mask);

    // R5
    f_only_fiq_chk: assert property (@(posedge clk) disable iff (rst)
        entry_valid && set_f_mask |-> entry_mode == 5'b10001 || entry_vec == '0);

    // R3
    fiq_vector_chk: assert property (@(posedge clk) disable iff (rst)
        entry_valid && entry_mode == 5'b10001 |-> entry_vec == AW'(32'h1C));

    // R6
    dabt_ret_chk: assert property (@(posedge clk) disable iff (rst)
        entry_valid && entry_vec == AW'(32'h10) |-> ret_addr == $past(fault_pc) + AW'(8));

    // R8
    fiq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        $past(boundary && f_masked) |-> !(entry_valid && entry_mode == 5'b10001));

    // R10
    quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !entry_valid |-> !save_status && !set_i_mask && !set_f_mask);
endmodule

bind exc_entry_ctrl exc_entry_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .boundary   (boundary),
    .f_masked   (f_masked),
    .fault_pc   (fault_pc),
    .entry_valid(entry_valid),
    .entry_vec  (entry_vec),
    .entry_mode (entry_mode),
    .set_i_mask (set_i_mask),
    .set_f_mask (set_f_mask),
    .ret_addr   (ret_addr),
    .save_status(save_status)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          boundary = 1'b0, dabt_req = 1'b0, pabt_req = 1'b0;
    logic          undef_req = 1'b0, swi_req = 1'b0;
    logic          fiq_n = 1'b1, irq_n = 1'b1, i_masked = 1'b0, f_masked = 1'b0;
    logic [AW-1:0] next_pc = '0, fault_pc = '0;
    logic          entry_valid, set_i_mask, set_f_mask, save_status;
    logic [AW-1:0] entry_vec, ret_addr;
    logic [4:0]    entry_mode;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    exc_entry_ctrl #(.AW(AW), .SYNC_STAGES(1)) u0 (.*);

    // kind codes: 0 none, 1 reset, 2 dabt, 3 fiq, 4 irq, 5 pabt, 6 undef, 7 swi
    typedef struct {
        logic          v;
        logic [AW-1:0] vec;
        logic [4:0]    mode;
        logic          si, sf, sv;
        logic [AW-1:0] ret;
        string         tag;
    } exp_t;

    exp_t q[$];

    function automatic exp_t expect_of(int k, logic [AW-1:0] npc, logic [AW-1:0] fpc, string tag);
        exp_t e;
        e = '{v:1'b1, vec:'0, mode:5'b0, si:1'b1, sf:1'b0, sv:1'b1, ret:'0, tag:tag};
        case (k)
            1: begin e.mode = 5'b10011; e.sf = 1'b1; e.sv = 1'b0; end
            2: begin e.vec = 16'h10; e.mode = 5'b10111; e.ret = fpc + 16'd8; end
            3: begin e.vec = 16'h1C; e.mode = 5'b10001; e.sf = 1'b1; e.ret = npc + 16'd4; end
            4: begin e.vec = 16'h18; e.mode = 5'b10010; e.ret = npc + 16'd4; end
            5: begin e.vec = 16'h0C; e.mode = 5'b10111; e.ret = fpc + 16'd4; end
            6: begin e.vec = 16'h04; e.mode = 5'b11011; e.ret = npc; end
            7: begin e.vec = 16'h08; e.mode = 5'b10011; e.ret = npc; end
            default: begin e.v = 1'b0; e.si = 1'b0; e.sv = 1'b0; end
        endcase
        return e;
    endfunction

    // driver: apply one cycle of stimulus, queue what the next output cycle must show
    task automatic step(input logic b, input logic da, input logic pa, input logic un,
                        input logic sw, input logic fq, input logic iq, input logic im,
                        input logic fm, input logic [AW-1:0] npc, input logic [AW-1:0] fpc,
                        input int kind, input string tag);
        @(negedge clk);
        boundary = b; dabt_req = da; pabt_req = pa; undef_req = un; swi_req = sw;
        fiq_n = fq; irq_n = iq; i_masked = im; f_masked = fm;
        next_pc = npc; fault_pc = fpc;
        @(posedge clk);
        #1;
        q.push_back(expect_of(kind, npc, fpc, tag));
    endtask

    // monitor: compare the registered outputs away from the clock edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (entry_valid !== e.v || (e.v && (entry_vec !== e.vec || entry_mode !== e.mode ||
                ret_addr !== e.ret)) || set_i_mask !== e.si || set_f_mask !== e.sf ||
                save_status !== e.sv) begin
                bad++;
                $display("FAIL %s: got v=%b vec=%h mode=%b i=%b f=%b sv=%b ret=%h exp v=%b vec=%h mode=%b i=%b f=%b sv=%b ret=%h",
                         e.tag, entry_valid, entry_vec, entry_mode, set_i_mask, set_f_mask,
                         save_status, ret_addr, e.v, e.vec, e.mode, e.si, e.sf, e.sv, e.ret);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (entry_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset state: got valid=%b exp 0", entry_valid);
        end
        // R1: reset entry right after release, no boundary
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        q.push_back(expect_of(1, '0, '0, "R1 reset entry"));
        // R9: requests without boundary
        step(0, 1, 1, 1, 0, 1, 1, 0, 0, 16'h0100, 16'h0200, 0, "R9 no boundary");
        // R3 R4 R6 single exceptions
        step(1, 0, 0, 1, 0, 1, 1, 0, 0, 16'h0300, 16'h0000, 6, "R3 R4 undef");
        step(1, 0, 0, 0, 1, 1, 1, 0, 0, 16'h0304, 16'h0000, 7, "R3 R4 swi");
        step(1, 0, 1, 0, 0, 1, 1, 0, 0, 16'h0400, 16'h0500, 5, "R6 pabt");
        step(1, 1, 0, 0, 0, 1, 1, 0, 0, 16'h0400, 16'h0600, 2, "R6 dabt");
        // R6: wrap modulo 2^AW
        step(1, 1, 0, 0, 0, 1, 1, 0, 0, 16'h0000, 16'hFFFC, 2, "R6 dabt wrap");
        // R2: pabt above undef
        step(1, 0, 1, 1, 0, 1, 1, 0, 0, 16'h0700, 16'h0710, 5, "R2 pabt over undef");
        // R7: irq drops at the boundary edge itself, not seen yet
        step(1, 0, 0, 0, 0, 1, 0, 0, 0, 16'h0800, 16'h0000, 0, "R7 irq not yet synced");
        step(1, 0, 1, 0, 0, 1, 0, 0, 0, 16'h0804, 16'h0810, 4, "R2 R7 irq over pabt");
        // R8: irq masked, pabt taken instead
        step(1, 0, 1, 0, 0, 1, 0, 1, 0, 16'h0808, 16'h0820, 5, "R8 irq masked");
        step(0, 0, 0, 0, 0, 1, 1, 0, 0, 16'h0000, 16'h0000, 0, "R10 idle");
        step(0, 0, 0, 0, 0, 1, 1, 0, 0, 16'h0000, 16'h0000, 0, "R10 idle");
        // R11: dabt and fiq together, fiq next boundary
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 16'h0900, 16'h0000, 0, "R9 fiq pending no boundary");
        step(1, 1, 0, 0, 0, 0, 1, 0, 0, 16'h0900, 16'h0950, 2, "R11 dabt beats fiq");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 16'h0A00, 16'h0000, 3, "R11 R5 fiq next boundary");
        // R8: fiq masked with irq also low, irq taken
        step(1, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0B00, 16'h0000, 4, "R8 fiq masked irq taken");
        // R8: both masked, nothing pending
        step(1, 0, 0, 0, 0, 0, 0, 1, 1, 16'h0B04, 16'h0000, 0, "R8 both masked");
        step(0, 0, 0, 0, 0, 1, 1, 0, 0, 16'h0000, 16'h0000, 0, "R10 idle");
        step(0, 0, 0, 0, 0, 1, 1, 0, 0, 16'h0000, 16'h0000, 0, "R10 idle");
        // R2: everything except reset, dabt wins
        step(1, 1, 1, 1, 0, 1, 1, 0, 0, 16'h0C00, 16'h0C40, 2, "R2 dabt top");
        step(0, 0, 0, 0, 0, 1, 1, 0, 0, 16'h0000, 16'h0000, 0, "R10 strobe single cycle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule